// File: doc/BRIEF.md
# Multiprocessor Boot and Pause Controller

This block sits on a single-cycle register port shared by the cores of a small multi-core cluster. Any core may issue an access; each access carries the requesting core's ID. Through this port software stores a 64-bit boot address and a 64-bit boot stack value. It can then bring a chosen secondary core online, or halt or resume every core except a chosen one.

For each core the block drives a run-enable level. It also drives a start strobe that lasts one cycle. While the strobe is high, the shared boot-address and stack outputs hold the values the core must load into its program counter and stack pointer. The port has no back-pressure and accepts an access in every cycle that `req_valid` is high. Each access gets a response exactly one cycle later on `rsp_valid`, with read data and an error flag. Writes return zero data.

Register offsets are ID = 0, core count = 1, start = 2, boot address = 3, boot stack = 4, pause = 5 and resume = 6. Every other offset is undecoded. A written core index is the full 64-bit `req_wdata` value.

Top module: `mpboot_ctrl`

## Requirements
- R1: After reset the boot address reads `BOOT_PC_RST` and the boot stack reads `BOOT_SP_RST`. `run_en` equals 1, so only core 0 runs, and `start_pulse` and `rsp_valid` are low.
- R2: Each access is answered on the cycle after it with `rsp_valid` high. A read of offset 0 returns the `req_core_id` of that access, zero-extended.
- R3: A read of offset 1 returns `N_CORES`. A write to offset 1 changes nothing that a later read can see.
- R4: A write of index k < `N_CORES` to offset 2 raises only `start_pulse[k]` for exactly one cycle, in the cycle after the write. In that cycle `start_pc` and `start_sp` equal the stored boot address and stack values, and `run_en[k]` is set.
- R5: A write to offset 3 or 4 with `req_wide` low stores `req_wdata[31:0]` sign-extended from bit 31, ignoring `req_wdata[63:32]`. With `req_wide` high it stores all 64 bits.
- R6: A write of index k < `N_CORES` to offset 5 clears every `run_en` bit except bit k, and leaves bit k unchanged.
- R7: A write of index k < `N_CORES` to offset 6 sets every `run_en` bit except bit k, and leaves bit k unchanged.
- R8: A write to offset 2, 5 or 6 whose 64-bit value is not below `N_CORES` changes neither `run_en` nor `start_pulse`.
- R9: An access to an undecoded offset returns zero data with `rsp_err` high for that one response cycle. A write to such an offset changes no stored value.
- R10: Reads of offsets 3 and 4 return the stored boot address and stack values.
- R11: A write to the boot address that lands in the cycle the start strobe is high does not alter the `start_pc` value carried by that strobe, and `start_pc` holds that value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| req_offset | input | OFF_W | Register offset |
| req_wdata | input | 64 | Write data or core index |
| req_core_id | input | IDX_W | ID of the requesting core |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 64 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Previous access hit an undecoded offset |
| run_en | output | N_CORES | Per-core run enable |
| start_pulse | output | N_CORES | One-cycle per-core start strobe |
| start_pc | output | 64 | Boot address carried with the strobe |
| start_sp | output | 64 | Stack value carried with the strobe |

## Verification
The start strobe leaves in the cycle after its write, so a second access can land in the very cycle the strobe is out. The bench issues a start write and, with no idle cycle between, a new boot-address write. It then judges that `start_pc` in the strobe cycle and afterwards still holds the old address, while a read-back shows the new one. The same back-to-back scheme is used to apply a start write followed by a pause write, checking that the freshly set run-enable is then cleared.

// File: rtl/mpboot_pkg.sv
package mpboot_pkg;
  localparam int DATA_W     = 64;
  localparam int OFF_ID     = 0;
  localparam int OFF_COUNT  = 1;
  localparam int OFF_START  = 2;
  localparam int OFF_BADDR  = 3;
  localparam int OFF_BSTACK = 4;
  localparam int OFF_PAUSE  = 5;
  localparam int OFF_RESUME = 6;

  typedef struct packed {
    logic id;
    logic count;
    logic start;
    logic baddr;
    logic bstack;
    logic pause;
    logic resume;
    logic hit;
  } sel_t;
endpackage

// File: rtl/mpboot_decode.sv
module mpboot_decode
  import mpboot_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic [OFF_W-1:0] offset,
  output sel_t             sel
);
  always_comb begin
    sel = '0;
    case (int'(offset))
      OFF_ID:     sel.id     = 1'b1;
      OFF_COUNT:  sel.count  = 1'b1;
      OFF_START:  sel.start  = 1'b1;
      OFF_BADDR:  sel.baddr  = 1'b1;
      OFF_BSTACK: sel.bstack = 1'b1;
      OFF_PAUSE:  sel.pause  = 1'b1;
      OFF_RESUME: sel.resume = 1'b1;
      default:    sel        = '0;
    endcase
    sel.hit = sel.id | sel.count | sel.start | sel.baddr |
              sel.bstack | sel.pause | sel.resume;
  end
endmodule

// File: rtl/mpboot_wide_reg.sv
module mpboot_wide_reg
  import mpboot_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wide,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d_val;

  always_comb begin
    if (wide) d_val = wdata;
    else      d_val = {{(DATA_W-32){wdata[31]}}, wdata[31:0]};
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= d_val;
  end

  // R5: narrow write with bit 31 set fills the upper half with ones
  p_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && wdata[31]) |=> (q[DATA_W-1:32] == '1));
  // R5: narrow write with bit 31 clear zeroes the upper half
  p_zext_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && !wdata[31]) |=> (q[DATA_W-1:32] == '0));
endmodule

// File: rtl/mpboot_run_ctrl.sv
module mpboot_run_ctrl
  import mpboot_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_fire,
  input  logic               pause_fire,
  input  logic               resume_fire,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  pc_in,
  input  logic [DATA_W-1:0]  sp_in,
  output logic [N_CORES-1:0] run_en,
  output logic [N_CORES-1:0] start_pulse,
  output logic [DATA_W-1:0]  start_pc,
  output logic [DATA_W-1:0]  start_sp
);
  logic [N_CORES-1:0] sel_mask;

  always_comb sel_mask = N_CORES'(1) << idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en      <= N_CORES'(1);
      start_pulse <= '0;
      start_pc    <= '0;
      start_sp    <= '0;
    end else begin
      start_pulse <= '0;
      if (start_fire) begin
        start_pulse <= sel_mask;
        run_en      <= run_en | sel_mask;
        start_pc    <= pc_in;
        start_sp    <= sp_in;
      end else if (pause_fire) begin
        run_en <= run_en & sel_mask;
      end else if (resume_fire) begin
        run_en <= run_en | ~sel_mask;
      end
    end
  end

  // R4: at most one core is strobed at a time
  p_pulse_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_pulse));
  // R4: a strobed core is running
  p_pulse_runs_r4: assert property (@(posedge clk) disable iff (rst)
    ((run_en & start_pulse) == start_pulse));
  // R6: after pause only the exempt core may still run
  p_pause_others_r6: assert property (@(posedge clk) disable iff (rst)
    pause_fire |=> ((run_en & ~$past(sel_mask)) == '0));
  // R6: the exempt core keeps its state
  p_pause_keep_r6: assert property (@(posedge clk) disable iff (rst)
    pause_fire |=> ((run_en & $past(sel_mask)) == ($past(run_en) & $past(sel_mask))));
  // R7: after resume every other core runs
  p_resume_others_r7: assert property (@(posedge clk) disable iff (rst)
    resume_fire |=> ((run_en | $past(sel_mask)) == '1));
endmodule

// File: rtl/mpboot_ctrl.sv
module mpboot_ctrl
  import mpboot_pkg::*;
#(
  parameter int                N_CORES     = 4,
  parameter int                OFF_W       = 3,
  parameter logic [DATA_W-1:0] BOOT_PC_RST = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [DATA_W-1:0] BOOT_SP_RST = 64'hFFFF_FFFF_A000_7F00,
  localparam int               IDX_W       = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [IDX_W-1:0]   req_core_id,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic [N_CORES-1:0] run_en,
  output logic [N_CORES-1:0] start_pulse,
  output logic [DATA_W-1:0]  start_pc,
  output logic [DATA_W-1:0]  start_sp
);
  sel_t              sel;
  logic              wr, rd, idx_ok;
  logic              start_fire, pause_fire, resume_fire;
  logic [DATA_W-1:0] boot_pc, boot_sp, rd_val;

  mpboot_decode #(.OFF_W(OFF_W)) u_dec (.offset(req_offset), .sel(sel));

  always_comb begin
    wr          = req_valid & req_write;
    rd          = req_valid & ~req_write;
    idx_ok      = (req_wdata < DATA_W'(N_CORES));
    start_fire  = wr & sel.start  & idx_ok;
    pause_fire  = wr & sel.pause  & idx_ok;
    resume_fire = wr & sel.resume & idx_ok;
  end

  mpboot_wide_reg #(.RST_VAL(BOOT_PC_RST)) u_pc_reg (
    .clk(clk), .rst(rst), .wr_en(wr & sel.baddr), .wide(req_wide),
    .wdata(req_wdata), .q(boot_pc));

  mpboot_wide_reg #(.RST_VAL(BOOT_SP_RST)) u_sp_reg (
    .clk(clk), .rst(rst), .wr_en(wr & sel.bstack), .wide(req_wide),
    .wdata(req_wdata), .q(boot_sp));

  mpboot_run_ctrl #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_run (
    .clk(clk), .rst(rst),
    .start_fire(start_fire), .pause_fire(pause_fire), .resume_fire(resume_fire),
    .idx(req_wdata[IDX_W-1:0]), .pc_in(boot_pc), .sp_in(boot_sp),
    .run_en(run_en), .start_pulse(start_pulse),
    .start_pc(start_pc), .start_sp(start_sp));

  always_comb begin
    rd_val = '0;
    if (rd) begin
      if (sel.id)     rd_val = DATA_W'(req_core_id);
      if (sel.count)  rd_val = DATA_W'(N_CORES);
      if (sel.baddr)  rd_val = boot_pc;
      if (sel.bstack) rd_val = boot_sp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~sel.hit;
      rsp_rdata <= rd_val;
    end
  end

  // R9: an error response carries no data
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  // R2: every access is answered next cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R8: out-of-range start index yields no strobe
  p_bad_start_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && sel.start && !idx_ok) |=> (start_pulse == '0));
  // R8: out-of-range pause/resume index leaves run enables alone
  p_bad_idx_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && (sel.pause || sel.resume) && !idx_ok) |=> (run_en == $past(run_en)));
  // R11: the strobe carries the boot values present at the start write
  p_pulse_value_r11: assert property (@(posedge clk) disable iff (rst)
    (start_fire) |=> (start_pc == $past(boot_pc) && start_sp == $past(boot_sp)));
endmodule

// File: tb/mpboot_ctrl_test.sv
module mpboot_ctrl_test;
  localparam int N = 4;
  localparam logic [63:0] PC_RST = 64'hFFFF_FFFF_BFC0_0000;
  localparam logic [63:0] SP_RST = 64'hFFFF_FFFF_A000_7F00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [2:0]  req_offset = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_core_id = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata, start_pc, start_sp;
  logic [N-1:0] run_en, start_pulse;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mpboot_ctrl #(.N_CORES(N), .OFF_W(3), .BOOT_PC_RST(PC_RST), .BOOT_SP_RST(SP_RST)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_offset(req_offset), .req_wdata(req_wdata),
    .req_core_id(req_core_id), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .run_en(run_en), .start_pulse(start_pulse),
    .start_pc(start_pc), .start_sp(start_sp));

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one access at a falling edge; returns at the next falling edge,
  // where the response and strobe for that access are visible
  task automatic drive(logic w, logic wide, logic [2:0] off, logic [63:0] d, logic [1:0] id);
    req_valid = 1'b1; req_write = w; req_wide = wide;
    req_offset = off; req_wdata = d; req_core_id = id;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic acc(logic w, logic wide, logic [2:0] off, logic [63:0] d, logic [1:0] id);
    @(negedge clk);
    drive(w, wide, off, d, id);
  endtask

  task automatic rd_chk(string tag, logic [2:0] off, logic [63:0] exp);
    acc(1'b0, 1'b0, off, 64'h0, 2'd0);
    chk(tag, rsp_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 run_en", 64'(run_en), 64'h1);
    chk("R1 pulse", 64'(start_pulse), 64'h0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    rd_chk("R1 boot addr", 3'd3, PC_RST);
    rd_chk("R1 boot stack", 3'd4, SP_RST);
  endtask

  task automatic t_identity;
    acc(1'b0, 1'b0, 3'd0, 64'h0, 2'd2);
    chk("R2 valid", 64'(rsp_valid), 64'h1);
    chk("R2 id 2", rsp_rdata, 64'd2);
    acc(1'b0, 1'b0, 3'd0, 64'h0, 2'd3);
    chk("R2 id 3", rsp_rdata, 64'd3);
  endtask

  task automatic t_count;
    rd_chk("R3 count", 3'd1, 64'd4);
    acc(1'b1, 1'b1, 3'd1, 64'd9, 2'd0);
    chk("R3 write err", 64'(rsp_err), 64'h0);
    rd_chk("R3 count after write", 3'd1, 64'd4);
  endtask

  task automatic t_sext;
    acc(1'b1, 1'b0, 3'd3, 64'hDEAD_BEEF_8000_1000, 2'd0);
    rd_chk("R5 narrow neg addr", 3'd3, 64'hFFFF_FFFF_8000_1000);
    acc(1'b1, 1'b0, 3'd4, 64'hDEAD_BEEF_7000_0010, 2'd0);
    rd_chk("R5 narrow pos stack", 3'd4, 64'h0000_0000_7000_0010);
    acc(1'b1, 1'b1, 3'd3, 64'h0000_0001_8000_0000, 2'd0);
    rd_chk("R5 wide addr", 3'd3, 64'h0000_0001_8000_0000);
  endtask

  task automatic t_start;
    acc(1'b1, 1'b1, 3'd3, 64'h1234_5678_9ABC_DEF0, 2'd0);
    acc(1'b1, 1'b1, 3'd4, 64'h0FED_CBA9_8765_4320, 2'd1);
    rd_chk("R10 addr readback", 3'd3, 64'h1234_5678_9ABC_DEF0);
    acc(1'b1, 1'b1, 3'd2, 64'd2, 2'd0);
    chk("R4 pulse core2", 64'(start_pulse), 64'h4);
    chk("R4 pc", start_pc, 64'h1234_5678_9ABC_DEF0);
    chk("R4 sp", start_sp, 64'h0FED_CBA9_8765_4320);
    chk("R4 run_en", 64'(run_en), 64'h5);
    @(negedge clk);
    chk("R4 pulse one cycle", 64'(start_pulse), 64'h0);
  endtask

  task automatic t_pause_resume;
    acc(1'b1, 1'b1, 3'd6, 64'd1, 2'd0);
    chk("R7 resume except 1", 64'(run_en), 64'hD);
    acc(1'b1, 1'b1, 3'd5, 64'd2, 2'd0);
    chk("R6 pause except 2", 64'(run_en), 64'h4);
    acc(1'b1, 1'b1, 3'd5, 64'd3, 2'd0);
    chk("R6 pause keeps idle 3", 64'(run_en), 64'h0);
    acc(1'b1, 1'b1, 3'd6, 64'd0, 2'd0);
    chk("R7 resume except 0", 64'(run_en), 64'hE);
  endtask

  task automatic t_bad_index;
    acc(1'b1, 1'b1, 3'd2, 64'd4, 2'd0);
    chk("R8 start oob pulse", 64'(start_pulse), 64'h0);
    chk("R8 start oob run", 64'(run_en), 64'hE);
    acc(1'b1, 1'b1, 3'd5, 64'd7, 2'd0);
    chk("R8 pause oob", 64'(run_en), 64'hE);
    acc(1'b1, 1'b1, 3'd6, 64'h1_0000_0000, 2'd0);
    chk("R8 resume high bits", 64'(run_en), 64'hE);
  endtask

  task automatic t_undecoded;
    acc(1'b0, 1'b0, 3'd7, 64'h0, 2'd1);
    chk("R9 read err", 64'(rsp_err), 64'h1);
    chk("R9 read zero", rsp_rdata, 64'h0);
    @(negedge clk);
    chk("R9 err one cycle", 64'(rsp_err), 64'h0);
    acc(1'b1, 1'b1, 3'd7, 64'h5555_5555_5555_5555, 2'd1);
    chk("R9 write err", 64'(rsp_err), 64'h1);
    rd_chk("R9 addr untouched", 3'd3, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R9 stack untouched", 3'd4, 64'h0FED_CBA9_8765_4320);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    drive(1'b1, 1'b1, 3'd2, 64'd1, 2'd0);
    chk("R11 pulse core1", 64'(start_pulse), 64'h2);
    chk("R11 pc in pulse", start_pc, 64'h1234_5678_9ABC_DEF0);
    drive(1'b1, 1'b1, 3'd3, 64'hAAAA_0000_BBBB_0000, 2'd0);
    chk("R11 pc held", start_pc, 64'h1234_5678_9ABC_DEF0);
    chk("R11 pulse ended", 64'(start_pulse), 64'h0);
    rd_chk("R11 new addr stored", 3'd3, 64'hAAAA_0000_BBBB_0000);
    // start followed at once by pause exempting core 0
    @(negedge clk);
    drive(1'b1, 1'b1, 3'd2, 64'd3, 2'd0);
    chk("R4 run core3 set", 64'(run_en[3]), 64'h1);
    drive(1'b1, 1'b1, 3'd5, 64'd0, 2'd0);
    chk("R6 pause after start", 64'(run_en), 64'h0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_count();
    t_sext();
    t_start();
    t_pause_resume();
    t_bad_index();
    t_undecoded();
    t_overlap();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule